// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Port

This block is the device-side port of a one-time-programmable program store while the device sits in its external programming state. A programmer drives three active-level strobes (chip enable, output enable, program pulse), an address and a byte. The block registers those pins and decodes them into operating modes. It collects up to four address/data pairs in a page buffer. On the falling edge of the program pulse it commits either the whole buffered page or one byte taken straight from the bus. During verify it returns stored bytes, and it releases the data bus in every other mode.

The storage is a behavioural byte array inside the block, erased to all ones at reset. Every write is a bitwise AND into a cell, so a bit can go from one to zero and never back. Addresses at or above the array depth are valid on the pins but reach no cell. The port is live only while the device reset pin is low and the programming supply indicator is high.

Top module: `otp_prog_if`

## Requirements
- R1: After reset the port does not drive the bus (`data_oe`=0) and every cell reads 8'hFF.
- R2: Unless `dev_reset_n`=0 and `prog_supply`=1, the port never drives the bus and program pulses change no cell.
- R3: Verify is `ce`=0, `oe`=0, `pgm`=1. Two clock edges after these pins are applied, `data_oe`=1 and `data_o` is the byte stored at `addr`.
- R4: When `oe`=1 or `ce`=1, `data_oe` is 0 two edges later, whatever the other strobes are.
- R5: Page load is `ce`=1, `oe`=0, `pgm`=1. Each clock in this mode stores `data_i` into buffer slot `addr[1:0]` and records page number `addr[ADDR_W-1:2]`. Loading alone changes no cell.
- R6: A falling `pgm` with `ce`=1 and `oe`=1 commits all four slots to addresses 4*page+slot. After the commit every slot returns to 8'hFF, so a later page commit leaves slots that were not reloaded unchanged.
- R7: A falling `pgm` with `ce`=0 and `oe`=1 writes `data_i` into the cell at `addr`.
- R8: A program pulse commits once, on its falling edge. Changes to `addr` or `data_i` while `pgm` stays low write nothing.
- R9: While `pgm` stays high (inhibit or standby), no cell changes.
- R10: A write stores the old cell value ANDed with the new byte, so bits can only be cleared.
- R11: Addresses at or above DEPTH (240 by default) are ignored by byte and page writes. Verify at such an address drives 8'hFF.
- R12: Loading the same slot twice before a page commit keeps only the last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_reset_n | input | 1 | Device reset pin; must be low for programming |
| prog_supply | input | 1 | Programming supply present |
| ce | input | 1 | Chip enable strobe |
| oe | input | 1 | Output enable strobe (low = read) |
| pgm | input | 1 | Program pulse, active low |
| addr | input | ADDR_W | Byte address |
| data_i | input | 8 | Data bus input |
| data_o | output | 8 | Data bus output value |
| data_oe | output | 1 | Data bus drive enable; 0 means high impedance |

## Verification
A wrong mode decode shows up two edges after the strobes change, either as `data_oe` rising outside verify or as a missing drive during verify. A stuck or leaking page buffer shows up only at the next page commit, as wrong bytes in neighbouring cells. The bench therefore reads back every slot and also the slots it did not reload. A wrong commit edge or a missing AND mask changes a cell at the pulse. That change becomes visible at the next verify of that address, so each write is followed by a readback of the written cell and of a nearby cell.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ERASED = '1;

  typedef enum logic [2:0] {
    PM_OFF,
    PM_IDLE,
    PM_LOAD,
    PM_PAGE_WR,
    PM_BYTE_WR,
    PM_VERIFY,
    PM_HOLD
  } otp_mode_e;
endpackage

// File: rtl/otp_strobe_decode.sv
module otp_strobe_decode
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_reset_n,
  input  logic              prog_supply,
  input  logic              ce,
  input  logic              oe,
  input  logic              pgm,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data_i,
  output otp_mode_e         mode,
  output logic              commit,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BYTE_W-1:0] data_q
);
  logic en_q, ce_q, oe_q, pgm_q, pgm_prev;
  logic en_nx, ce_nx, oe_nx, pgm_nx, prev_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [BYTE_W-1:0] data_nx;

  always_comb begin
    en_nx   = ~dev_reset_n & prog_supply;
    ce_nx   = ce;
    oe_nx   = oe;
    pgm_nx  = pgm;
    prev_nx = pgm_q;
    addr_nx = addr;
    data_nx = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ce_q     <= 1'b1;
      oe_q     <= 1'b1;
      pgm_q    <= 1'b1;
      pgm_prev <= 1'b1;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      en_q     <= en_nx;
      ce_q     <= ce_nx;
      oe_q     <= oe_nx;
      pgm_q    <= pgm_nx;
      pgm_prev <= prev_nx;
      addr_q   <= addr_nx;
      data_q   <= data_nx;
    end
  end

  always_comb begin
    if (!en_q) begin
      mode = PM_OFF;
    end else begin
      case ({ce_q, oe_q, pgm_q})
        3'b101:  mode = PM_LOAD;
        3'b110:  mode = PM_PAGE_WR;
        3'b010:  mode = PM_BYTE_WR;
        3'b001:  mode = PM_VERIFY;
        3'b111,
        3'b011:  mode = PM_HOLD;
        default: mode = PM_IDLE;
      endcase
    end
  end

  assign commit = en_q & pgm_prev & ~pgm_q;
endmodule

// File: rtl/otp_page_buffer.sv
module otp_page_buffer
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SLOT_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic                         flush,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BYTE_W-1:0]            data,
  output logic [ADDR_W-SLOT_W-1:0]     page_idx,
  output logic [(1<<SLOT_W)*BYTE_W-1:0] slots
);
  localparam int NSLOT = 1 << SLOT_W;

  logic [(1<<SLOT_W)*BYTE_W-1:0] slots_nx;
  logic [ADDR_W-SLOT_W-1:0]     page_nx;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_comb begin
      slots_nx[s*BYTE_W +: BYTE_W] = slots[s*BYTE_W +: BYTE_W];
      if (flush) begin
        slots_nx[s*BYTE_W +: BYTE_W] = ERASED;
      end else if (load && addr[SLOT_W-1:0] == SLOT_W'(s)) begin
        slots_nx[s*BYTE_W +: BYTE_W] = data;
      end
    end
  end

  always_comb begin
    page_nx = page_idx;
    if (load) page_nx = addr[ADDR_W-1:SLOT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots    <= '1;
      page_idx <= '0;
    end else begin
      slots    <= slots_nx;
      page_idx <= page_nx;
    end
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 240,
  parameter int SLOT_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          byte_we,
  input  logic [ADDR_W-1:0]             byte_addr,
  input  logic [BYTE_W-1:0]             byte_data,
  input  logic                          page_we,
  input  logic [ADDR_W-SLOT_W-1:0]      page_idx,
  input  logic [(1<<SLOT_W)*BYTE_W-1:0] page_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [BYTE_W-1:0]             rd_data
);
  localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(DEPTH);

  logic [BYTE_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam int SL = i % (1 << SLOT_W);
    logic [BYTE_W-1:0] bmask, pmask, cell_nx;

    always_comb begin
      bmask = ERASED;
      pmask = ERASED;
      if (byte_we && byte_addr == ADDR_W'(i)) bmask = byte_data;
      if (page_we && page_idx == (ADDR_W-SLOT_W)'(i >> SLOT_W))
        pmask = page_data[SL*BYTE_W +: BYTE_W];
      cell_nx = cells[i] & bmask & pmask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cells[i] <= ERASED;
      else        cells[i] <= cell_nx;
    end
  end

  always_comb begin
    if ({1'b0, rd_addr} < DEPTH_L) rd_data = cells[rd_addr];
    else                           rd_data = ERASED;
  end
endmodule

// File: rtl/otp_prog_if.sv
module otp_prog_if
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_reset_n,
  input  logic              prog_supply,
  input  logic              ce,
  input  logic              oe,
  input  logic              pgm,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe
);
  localparam int SLOT_W = 2;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  otp_mode_e          mode;
  logic               commit;
  logic [ADDR_W-1:0]  addr_q;
  logic [BYTE_W-1:0]  data_q;
  logic               byte_we, page_we, load;
  logic [PAGE_W-1:0]  page_idx;
  logic [NSLOT*BYTE_W-1:0] slots;
  logic [BYTE_W-1:0]  rd_data;
  logic [BYTE_W-1:0]  dout_nx;
  logic               drive_nx;

  otp_strobe_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_int_n),
    .dev_reset_n(dev_reset_n), .prog_supply(prog_supply),
    .ce(ce), .oe(oe), .pgm(pgm), .addr(addr), .data_i(data_i),
    .mode(mode), .commit(commit), .addr_q(addr_q), .data_q(data_q)
  );

  assign load    = (mode == PM_LOAD);
  assign byte_we = commit && (mode == PM_BYTE_WR);
  assign page_we = commit && (mode == PM_PAGE_WR);

  otp_page_buffer #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_buf (
    .clk(clk), .rst_n(rst_int_n),
    .load(load), .flush(page_we),
    .addr(addr_q), .data(data_q),
    .page_idx(page_idx), .slots(slots)
  );

  otp_cell_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_arr (
    .clk(clk), .rst_n(rst_int_n),
    .byte_we(byte_we), .byte_addr(addr_q), .byte_data(data_q),
    .page_we(page_we), .page_idx(page_idx), .page_data(slots),
    .rd_addr(addr_q), .rd_data(rd_data)
  );

  always_comb begin
    drive_nx = (mode == PM_VERIFY);
    dout_nx  = drive_nx ? rd_data : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      data_oe <= 1'b0;
      data_o  <= '0;
    end else begin
      data_oe <= drive_nx;
      data_o  <= dout_nx;
    end
  end
endmodule

// File: rtl/otp_prog_if_chk.sv
module otp_prog_if_chk #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 240
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_reset_n,
  input logic              prog_supply,
  input logic              ce,
  input logic              oe,
  input logic              pgm,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        data_o,
  input logic              data_oe,
  input logic              byte_we,
  input logic              page_we
);
  localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(DEPTH);

  // R2: drive only when programming state was present at the pins
  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> ($past(!dev_reset_n, 2) && $past(prog_supply, 2)));

  // R3: drive only after verify strobes
  assert_verify_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> ($past(!ce, 2) && $past(!oe, 2) && $past(pgm, 2)));

  // R4: output enable high or chip enable high releases the bus
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce, 2) || $past(oe, 2)) |-> !data_oe);

  // R7: byte commit only after a low pulse with ce low, oe high
  assert_byte_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |-> ($past(!pgm) && $past(!ce) && $past(oe)));

  // R6: page commit only after a low pulse with ce high, oe high
  assert_page_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |-> ($past(!pgm) && $past(ce) && $past(oe)));

  // R8: one commit per pulse
  assert_single_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we || page_we) |=> !(byte_we || page_we));

  // R10: repeated verify of one address never shows a bit going to one
  assert_clear_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe) && ($past(addr, 2) == $past(addr, 3)))
      |-> ((data_o & ~$past(data_o)) == 8'h00));

  // R11: verify beyond the array returns the erased value
  assert_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && ({1'b0, $past(addr, 2)} >= DEPTH_L)) |-> (data_o == 8'hFF));
endmodule

bind otp_prog_if otp_prog_if_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_reset_n(dev_reset_n), .prog_supply(prog_supply),
  .ce(ce), .oe(oe), .pgm(pgm), .addr(addr), .data_o(data_o), .data_oe(data_oe),
  .byte_we(byte_we), .page_we(page_we)
);

// File: tb/tb_otp_prog_if.sv
`timescale 1ns/1ps
module tb_otp_prog_if;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 240;

  logic clk, rst_n, dev_reset_n, prog_supply, ce, oe, pgm;
  logic [ADDR_W-1:0] addr;
  logic [7:0] data_i, data_o;
  logic data_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  otp_prog_if #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .dev_reset_n(dev_reset_n), .prog_supply(prog_supply),
    .ce(ce), .oe(oe), .pgm(pgm), .addr(addr), .data_i(data_i),
    .data_o(data_o), .data_oe(data_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic c, input logic o, input logic p,
                      input logic [ADDR_W-1:0] a, input logic [7:0] d);
    ce = c; oe = o; pgm = p; addr = a; data_i = d;
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual oe/data=%h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic ex_oe,
                    input logic [7:0] ex_d, input string req);
    pins(0, 0, 1, a, 8'h00);
    step(2);
    check(req, {data_oe, data_o}, {ex_oe, ex_d});
  endtask

  task automatic bw(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    pins(0, 1, 1, a, d); step(1);
    pins(0, 1, 0, a, d); step(2);
    pins(0, 1, 1, a, d); step(1);
  endtask

  task automatic ld(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    pins(1, 0, 1, a, d); step(1);
  endtask

  task automatic pw();
    pins(1, 1, 1, addr, 8'h00); step(1);
    pins(1, 1, 0, addr, 8'h00); step(2);
    pins(1, 1, 1, addr, 8'h00); step(1);
  endtask

  task automatic t_reset();
    check("R1 idle after reset", {data_oe, data_o}, 9'h000);
    rd(8'd0,   1'b1, 8'hFF, "R1 cell 0 erased");
    rd(8'd239, 1'b1, 8'hFF, "R1 last cell erased");
    rd(8'd7,   1'b1, 8'hFF, "R3 verify drives stored byte");
  endtask

  task automatic t_release();
    pins(0, 1, 1, 8'd3, 8'h00); step(2);
    check("R4 oe high releases", {data_oe, data_o}, 9'h000);
    pins(1, 1, 1, 8'd3, 8'h00); step(2);
    check("R4 standby releases", {data_oe, data_o}, 9'h000);
    pins(1, 0, 0, 8'd3, 8'h00); step(2);
    check("R4 ce high with oe low releases", {data_oe, data_o}, 9'h000);
  endtask

  task automatic t_byte();
    bw(8'd20, 8'hAA);
    rd(8'd20, 1'b1, 8'hAA, "R7 byte written");
    rd(8'd21, 1'b1, 8'hFF, "R7 neighbour untouched");
  endtask

  task automatic t_hold();
    pins(0, 1, 1, 8'd30, 8'hC3); step(1);
    pins(0, 1, 0, 8'd30, 8'hC3); step(2);
    pins(0, 1, 0, 8'd30, 8'h00); step(3);
    pins(0, 1, 0, 8'd31, 8'h00); step(2);
    pins(0, 1, 1, 8'd31, 8'h00); step(1);
    rd(8'd30, 1'b1, 8'hC3, "R8 no rewrite during held pulse");
    rd(8'd31, 1'b1, 8'hFF, "R8 address change while low ignored");
  endtask

  task automatic t_inhibit();
    pins(0, 1, 1, 8'd40, 8'h00); step(4);
    pins(1, 1, 1, 8'd40, 8'h00); step(4);
    rd(8'd40, 1'b1, 8'hFF, "R9 pgm high writes nothing");
  endtask

  task automatic t_and();
    bw(8'd50, 8'h3C);
    bw(8'd50, 8'hF5);
    rd(8'd50, 1'b1, 8'h34, "R10 second write ANDs");
    bw(8'd50, 8'hFF);
    rd(8'd50, 1'b1, 8'h34, "R10 ones cannot be restored");
  endtask

  task automatic t_page();
    ld(8'd8, 8'h11); ld(8'd9, 8'h22); ld(8'd9, 8'h99);
    ld(8'd10, 8'h33); ld(8'd11, 8'h44);
    rd(8'd8, 1'b1, 8'hFF, "R5 load alone writes nothing");
    pw();
    rd(8'd8,  1'b1, 8'h11, "R6 slot0 committed");
    rd(8'd9,  1'b1, 8'h99, "R12 last load wins");
    rd(8'd10, 1'b1, 8'h33, "R6 slot2 committed");
    rd(8'd11, 1'b1, 8'h44, "R6 slot3 committed");
    ld(8'd16, 8'h5A);
    pw();
    rd(8'd16, 1'b1, 8'h5A, "R5 new page number used");
    rd(8'd17, 1'b1, 8'hFF, "R6 slots cleared after commit");
  endtask

  task automatic t_range();
    bw(8'd245, 8'h00);
    rd(8'd245, 1'b1, 8'hFF, "R11 read beyond depth is erased");
    rd(8'd5,   1'b1, 8'hFF, "R11 no alias of byte write");
    ld(8'd240, 8'h00); ld(8'd241, 8'h00); ld(8'd242, 8'h00); ld(8'd243, 8'h00);
    pw();
    rd(8'd240, 1'b1, 8'hFF, "R11 page beyond depth ignored");
    rd(8'd0,   1'b1, 8'hFF, "R11 no alias of page write");
  endtask

  task automatic t_gate();
    dev_reset_n = 1'b1; step(2);
    rd(8'd20, 1'b0, 8'h00, "R2 no drive with device reset high");
    bw(8'd60, 8'h00);
    dev_reset_n = 1'b0; step(2);
    rd(8'd60, 1'b1, 8'hFF, "R2 no write with device reset high");
    prog_supply = 1'b0; step(2);
    rd(8'd20, 1'b0, 8'h00, "R2 no drive without supply");
    bw(8'd61, 8'h00);
    prog_supply = 1'b1; step(2);
    rd(8'd61, 1'b1, 8'hFF, "R2 no write without supply");
    rd(8'd20, 1'b1, 8'hAA, "R3 contents kept after gating");
  endtask

  initial begin
    rst_n = 1'b0; dev_reset_n = 1'b0; prog_supply = 1'b1;
    pins(1, 1, 1, '0, 8'h00);
    step(5);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_release();
    t_byte();
    t_hold();
    t_inhibit();
    t_and();
    t_page();
    t_range();
    t_gate();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule